// File: doc/BRIEF.md
# Waveform Mask Match Trigger

This block watches a stream of acquired samples, two per clock, and raises a trigger when the most recent stretch of the waveform fits entirely inside a keep-in mask. The mask is a chain of NUM_STAGES (upper, lower) limit pairs. Software loads the pairs one at a time before arming. Each sample carries a max and a min value. The two values are equal for a raw sample and differ when an upstream stage has summarised several samples. The block keeps a history of the last NUM_STAGES+1 samples. It compares every history position with its limit pair in parallel and ANDs all the results in one cycle.

Two samples arrive per clock, so two window alignments can complete in each clock. One alignment ends on the later sample (lane 1) and the other ends on the earlier sample (lane 0). The block reports which lane completed the match. When the mask trigger is enabled, it replaces the normal reference-trigger source. When it is disabled, the normal source passes straight through.

Top module: `wave_mask_trigger`

## Requirements
- R1: A limit pair is accepted only on a rising edge of `cfg_valid_i`. Holding it high for further cycles writes nothing more.
- R2: Each accepted pair enters limit position 0 and moves every stored pair one position deeper. Limit position j is compared with the sample that is j samples older than the newest sample of the window, so the first pair written lines up with the oldest sample.
- R3: `cfg_done_o` is high for exactly one cycle, the cycle after the rising edge of `cfg_valid_i`, once the pair is stored.
- R4: `stage_count_o` always reads NUM_STAGES.
- R5: The sample history shifts only in cycles with `smp_valid_i` high, by two positions per shift. Sample input values in other cycles have no effect. The limits stay fixed while samples shift.
- R6: A position is in range only when its sample max is strictly less than the upper limit and its sample min is strictly greater than the lower limit. All values are signed two's complement.
- R7: A match is reported on `trig_o` in the cycle after the accepted sample pair. It lasts exactly that one cycle and is computed from all positions at once.
- R8: The lane-1 alignment compares the newest NUM_STAGES samples (the lane-1 sample at position 0). The lane-0 alignment compares the NUM_STAGES samples ending at the newest lane-0 sample. `trig_lane_o` gives the completing lane (0 or 1). It reads 1 while the block is enabled and there is no match.
- R9: If both alignments match in the same cycle, `trig_lane_o` is 0.
- R10: A history position counts as out of range until a sample received while enabled has reached it. Dropping the enable clears this fill state.
- R11: With `en_i` low, `trig_o` equals `ref_trig_i` and `trig_lane_o` equals `ref_lane_i` in the same cycle.
- R12: After reset, `cfg_done_o` is 0 and all limits, history and fill state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables the mask trigger and its fill tracking |
| cfg_valid_i | input | 1 | Limit write strobe; its rising edge writes a pair |
| cfg_upper_i | input | DATA_W | Upper limit of the pair being written (signed) |
| cfg_lower_i | input | DATA_W | Lower limit of the pair being written (signed) |
| cfg_done_o | output | 1 | One-cycle acknowledge that the pair is stored |
| stage_count_o | output | $clog2(NUM_STAGES+1) | Number of limit pairs supported |
| smp_valid_i | input | 1 | Sample pair valid |
| smp0_max_i | input | DATA_W | Earlier sample (lane 0), max value |
| smp0_min_i | input | DATA_W | Earlier sample (lane 0), min value |
| smp1_max_i | input | DATA_W | Later sample (lane 1), max value |
| smp1_min_i | input | DATA_W | Later sample (lane 1), min value |
| ref_trig_i | input | 1 | Normal reference-trigger source |
| ref_lane_i | input | 1 | Lane index of the normal source |
| trig_o | output | 1 | Reference trigger out |
| trig_lane_o | output | 1 | Lane index that caused `trig_o` |

## Verification
A wrong limit or history entry has no output of its own. It shows up only as a missing or extra `trig_o` pulse, or a wrong lane index. That happens on the first sample pair whose window covers the bad position with a value near that position's limits, and it can appear as late as NUM_STAGES/2+1 pushes after the fault. The bench therefore loads limits that differ by position and streams many pseudo-random pairs close to those limits. It compares every push against its own model of the window. A fill-state fault shows directly as a trigger in the first cycles after enable. A shift that happens without a valid strobe shows as a mismatch on the next match decision.

// File: rtl/wmt_pkg.sv
package wmt_pkg;

  typedef enum logic {
    LANE_EARLY = 1'b0,
    LANE_LATE  = 1'b1
  } lane_e;

  // saturating add used for the fill tracker
  function automatic int unsigned sat_add(input int unsigned cur,
                                          input int unsigned inc,
                                          input int unsigned cap);
    int unsigned sum;
    sum = cur + inc;
    return (sum > cap) ? cap : sum;
  endfunction

endpackage

// File: rtl/wmt_limit_chain.sv
module wmt_limit_chain #(
  parameter int K = 8,
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid_i,
  input  logic [W-1:0]        up_i,
  input  logic [W-1:0]        lo_i,
  output logic                done_o,
  output logic [K-1:0][W-1:0] lim_up_o,
  output logic [K-1:0][W-1:0] lim_lo_o
);

  logic valid_q;
  logic wr_accept;

  // write qualifies only on the rising edge of the strobe
  assign wr_accept = cfg_valid_i & ~valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      done_o   <= 1'b0;
      lim_up_o <= '0;
      lim_lo_o <= '0;
    end else begin
      valid_q <= cfg_valid_i;
      done_o  <= wr_accept;
      if (wr_accept) begin
        lim_up_o[0] <= up_i;
        lim_lo_o[0] <= lo_i;
        for (int i = 1; i < K; i++) begin
          lim_up_o[i] <= lim_up_o[i-1];
          lim_lo_o[i] <= lim_lo_o[i-1];
        end
      end
    end
  end

  assert_done_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> done_o);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_limits_static_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> ($stable(lim_up_o) && $stable(lim_lo_o)));

endmodule

// File: rtl/wmt_sample_hist.sv
module wmt_sample_hist #(
  parameter int K  = 8,
  parameter int W  = 12,
  parameter int FW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [W-1:0]      early_max_i,
  input  logic [W-1:0]      early_min_i,
  input  logic [W-1:0]      late_max_i,
  input  logic [W-1:0]      late_min_i,
  output logic [K:0][W-1:0] h_max_o,
  output logic [K:0][W-1:0] h_min_o,
  output logic [FW-1:0]     fill_o,
  output logic              fresh_o
);
  import wmt_pkg::*;

  localparam int unsigned DEPTH = K + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_max_o <= '0;
      h_min_o <= '0;
      fill_o  <= '0;
      fresh_o <= 1'b0;
    end else begin
      fresh_o <= valid_i;
      if (valid_i) begin
        h_max_o[0] <= late_max_i;
        h_min_o[0] <= late_min_i;
        h_max_o[1] <= early_max_i;
        h_min_o[1] <= early_min_i;
        for (int i = 2; i <= K; i++) begin
          h_max_o[i] <= h_max_o[i-2];
          h_min_o[i] <= h_min_o[i-2];
        end
      end
      if (!en_i)
        fill_o <= '0;
      else if (valid_i)
        fill_o <= FW'(sat_add(int'(fill_o), 2, DEPTH));
    end
  end

  assert_hist_static_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(h_max_o) && $stable(h_min_o)));

  assert_fill_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (fill_o == '0));

endmodule

// File: rtl/wmt_match_array.sv
module wmt_match_array #(
  parameter int K  = 8,
  parameter int W  = 12,
  parameter int FW = 4
) (
  input  logic [K:0][W-1:0]   h_max_i,
  input  logic [K:0][W-1:0]   h_min_i,
  input  logic [K-1:0][W-1:0] lim_up_i,
  input  logic [K-1:0][W-1:0] lim_lo_i,
  input  logic [FW-1:0]       fill_i,
  input  logic                fresh_i,
  output logic                match_late_o,
  output logic                match_early_o
);

  // strict keep-in test on signed values
  function automatic logic keep_in(input logic [W-1:0] mx, input logic [W-1:0] mn,
                                   input logic [W-1:0] up, input logic [W-1:0] lo);
    return ($signed(mx) < $signed(up)) && ($signed(mn) > $signed(lo));
  endfunction

  logic [K-1:0] ok_late;
  logic [K-1:0] ok_early;

  // two comparators per limit position: one per window alignment
  for (genvar j = 0; j < K; j++) begin : g_pos
    assign ok_late[j]  = keep_in(h_max_i[j], h_min_i[j], lim_up_i[j], lim_lo_i[j])
                         && (int'(fill_i) > j);
    assign ok_early[j] = keep_in(h_max_i[j+1], h_min_i[j+1], lim_up_i[j], lim_lo_i[j])
                         && (int'(fill_i) > j + 1);
  end

  assign match_late_o  = fresh_i & (&ok_late);
  assign match_early_o = fresh_i & (&ok_early);

endmodule

// File: rtl/wave_mask_trigger.sv
module wave_mask_trigger #(
  parameter int NUM_STAGES = 8,
  parameter int DATA_W     = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en_i,
  input  logic                              cfg_valid_i,
  input  logic [DATA_W-1:0]                 cfg_upper_i,
  input  logic [DATA_W-1:0]                 cfg_lower_i,
  output logic                              cfg_done_o,
  output logic [$clog2(NUM_STAGES+1)-1:0]   stage_count_o,
  input  logic                              smp_valid_i,
  input  logic [DATA_W-1:0]                 smp0_max_i,
  input  logic [DATA_W-1:0]                 smp0_min_i,
  input  logic [DATA_W-1:0]                 smp1_max_i,
  input  logic [DATA_W-1:0]                 smp1_min_i,
  input  logic                              ref_trig_i,
  input  logic                              ref_lane_i,
  output logic                              trig_o,
  output logic                              trig_lane_o
);
  import wmt_pkg::*;

  localparam int CW = $clog2(NUM_STAGES + 1);
  localparam int FW = $clog2(NUM_STAGES + 2);

  logic [NUM_STAGES-1:0][DATA_W-1:0] lim_up;
  logic [NUM_STAGES-1:0][DATA_W-1:0] lim_lo;
  logic [NUM_STAGES:0][DATA_W-1:0]   h_max;
  logic [NUM_STAGES:0][DATA_W-1:0]   h_min;
  logic [FW-1:0]                     fill;
  logic                              fresh;
  logic                              m_late;
  logic                              m_early;
  lane_e                             mask_lane;

  assign stage_count_o = CW'(NUM_STAGES);

  wmt_limit_chain #(.K(NUM_STAGES), .W(DATA_W)) u_limits (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid_i (cfg_valid_i),
    .up_i        (cfg_upper_i),
    .lo_i        (cfg_lower_i),
    .done_o      (cfg_done_o),
    .lim_up_o    (lim_up),
    .lim_lo_o    (lim_lo)
  );

  wmt_sample_hist #(.K(NUM_STAGES), .W(DATA_W), .FW(FW)) u_hist (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .valid_i     (smp_valid_i),
    .early_max_i (smp0_max_i),
    .early_min_i (smp0_min_i),
    .late_max_i  (smp1_max_i),
    .late_min_i  (smp1_min_i),
    .h_max_o     (h_max),
    .h_min_o     (h_min),
    .fill_o      (fill),
    .fresh_o     (fresh)
  );

  wmt_match_array #(.K(NUM_STAGES), .W(DATA_W), .FW(FW)) u_match (
    .h_max_i       (h_max),
    .h_min_i       (h_min),
    .lim_up_i      (lim_up),
    .lim_lo_i      (lim_lo),
    .fill_i        (fill),
    .fresh_i       (fresh),
    .match_late_o  (m_late),
    .match_early_o (m_early)
  );

  // earlier lane wins a tie
  assign mask_lane   = m_early ? LANE_EARLY : LANE_LATE;
  assign trig_o      = en_i ? (m_late | m_early) : ref_trig_i;
  assign trig_lane_o = en_i ? logic'(mask_lane) : ref_lane_i;

  assert_no_early_late_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) < NUM_STAGES) |-> !m_late);

  assert_no_early_early_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) < NUM_STAGES + 1) |-> !m_early);

  assert_match_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_late | m_early) |-> $past(smp_valid_i));

  assert_tie_lane_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && m_early && m_late) |-> (trig_o && !trig_lane_o));

endmodule

// File: tb/wave_mask_trigger_tb_top.sv
`timescale 1ns/1ps
module wave_mask_trigger_tb_top;

  localparam int K = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en, cfg_valid, cfg_done, smp_valid, ref_trig, ref_lane, trig, trig_lane;
  logic [W-1:0] cfg_up, cfg_lo, s0_max, s0_min, s1_max, s1_min;
  logic [$clog2(K+1)-1:0] stage_count;

  wave_mask_trigger #(.NUM_STAGES(K), .DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en),
    .cfg_valid_i(cfg_valid), .cfg_upper_i(cfg_up), .cfg_lower_i(cfg_lo),
    .cfg_done_o(cfg_done), .stage_count_o(stage_count),
    .smp_valid_i(smp_valid), .smp0_max_i(s0_max), .smp0_min_i(s0_min),
    .smp1_max_i(s1_max), .smp1_min_i(s1_min),
    .ref_trig_i(ref_trig), .ref_lane_i(ref_lane),
    .trig_o(trig), .trig_lane_o(trig_lane)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model: mlim[j] compared with sample of age j (age 0 newest)
  int mlim_up [K];
  int mlim_lo [K];
  int mh_max  [K+1];
  int mh_min  [K+1];
  int mfill = 0;
  bit men = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  // alignment ending at age 'ofs': count positions that break the mask
  function automatic bit window_ok(input int ofs);
    int bad = 0;
    if (mfill < K + ofs) return 0;
    for (int j = K - 1; j >= 0; j--)
      if (!(mh_max[j+ofs] < mlim_up[j]) || !(mh_min[j+ofs] > mlim_lo[j])) bad++;
    return bad == 0;
  endfunction

  function automatic int rnd(input int span, input int base);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return base + int'(lfsr % 16'(span));
  endfunction

  task automatic write_lim(input int up, input int lo);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_up = W'(up); cfg_lo = W'(lo);
    @(negedge clk);
    chk("R3 done after write", int'(cfg_done), 1);
    cfg_valid = 1'b0;
    for (int i = K - 1; i >= 1; i--) begin
      mlim_up[i] = mlim_up[i-1]; mlim_lo[i] = mlim_lo[i-1];
    end
    mlim_up[0] = up; mlim_lo[0] = lo;
    @(negedge clk);
    chk("R3 done one cycle", int'(cfg_done), 0);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    en = v; men = v;
    if (!v) mfill = 0;
  endtask

  task automatic push(input string req, input int e_mx, input int e_mn,
                      input int l_mx, input int l_mn);
    bit xl, xe, xt;
    @(negedge clk);
    smp_valid = 1'b1;
    s0_max = W'(e_mx); s0_min = W'(e_mn); s1_max = W'(l_mx); s1_min = W'(l_mn);
    for (int i = K; i >= 2; i--) begin
      mh_max[i] = mh_max[i-2]; mh_min[i] = mh_min[i-2];
    end
    mh_max[1] = e_mx; mh_min[1] = e_mn; mh_max[0] = l_mx; mh_min[0] = l_mn;
    if (men) mfill = (mfill + 2 > K + 1) ? K + 1 : mfill + 2;
    xl = window_ok(0);
    xe = window_ok(1);
    xt = men ? (xl | xe) : ref_trig;
    @(negedge clk);
    smp_valid = 1'b0;
    s0_max = 8'h7F; s0_min = 8'h80; s1_max = 8'h80; s1_min = 8'h7F;
    chk(req, int'(trig), int'(xt));
    if (men && xt) chk({req, " lane"}, int'(trig_lane), xe ? 0 : 1);
    @(negedge clk);
    if (men) chk("R7 single-cycle pulse", int'(trig), 0);
  endtask

  task automatic idle_garbage(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      s0_max = W'(rnd(256, 0)); s0_min = W'(rnd(256, 0));
      s1_max = W'(rnd(256, 0)); s1_min = W'(rnd(256, 0));
      if (men) chk("R5 idle no trigger", int'(trig), 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int a, b;
    for (int i = 0; i < K; i++) begin mlim_up[i] = 0; mlim_lo[i] = 0; end
    for (int i = 0; i <= K; i++) begin mh_max[i] = 0; mh_min[i] = 0; end
    rst_n = 0; en = 0; cfg_valid = 0; cfg_up = '0; cfg_lo = '0;
    smp_valid = 0; s0_max = '0; s0_min = '0; s1_max = '0; s1_min = '0;
    ref_trig = 0; ref_lane = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset done low", int'(cfg_done), 0);
    chk("R12 reset trig", int'(trig), 0);
    chk("R4 stage count", int'(stage_count), K);

    // R11 pass-through of the normal source
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      ref_trig = c[0]; ref_lane = c[1];
      #1;
      chk("R11 pass trig", int'(trig), c & 1);
      chk("R11 pass lane", int'(trig_lane), (c >> 1) & 1);
    end
    ref_trig = 0; ref_lane = 0;

    // R2 uniform wide mask
    for (int i = 0; i < K; i++) write_lim(20, -20);
    // R1 held strobe writes once
    @(negedge clk);
    cfg_valid = 1'b1; cfg_up = W'(30); cfg_lo = W'(-30);
    @(negedge clk);
    chk("R1 first edge done", int'(cfg_done), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 held strobe no done", int'(cfg_done), 0);
    end
    cfg_valid = 1'b0;
    for (int i = K - 1; i >= 1; i--) begin
      mlim_up[i] = mlim_up[i-1]; mlim_lo[i] = mlim_lo[i-1];
    end
    mlim_up[0] = 30; mlim_lo[0] = -30;

    // R10 fill, then R9 tie
    set_en(1);
    push("R10 not filled", 0, 0, 0, 0);
    push("R10 lane1 window filled", 0, 0, 0, 0);
    push("R9 both windows lane0", 0, 0, 0, 0);
    // R1: deepest pairs must still be 20/-20, so 25 breaks them
    push("R1 R2 deep limit kept", 25, 0, 0, 0);
    push("R8 early sample aged", 0, 0, 0, 0);
    push("R8 lane1 only", 0, 0, 0, 0);
    push("R8 tail", 0, 0, 0, 0);
    set_en(0);
    set_en(1);
    push("R10 refill after enable", 0, 0, 0, 0);

    // R6 strict boundaries on a tight mask
    for (int i = 0; i < K; i++) write_lim(5, -5);
    push("R6 fill", 0, 0, 0, 0);
    push("R6 fill", 0, 0, 0, 0);
    push("R6 fill", 0, 0, 0, 0);
    push("R6 upper equal", 0, 0, 5, 0);
    push("R6 lower equal", 0, -5, 4, -4);
    push("R6 just inside", 4, -4, 4, -4);
    push("R6 just inside", 4, -4, 4, -4);
    push("R6 just inside", 4, -4, 4, -4);

    // R2 R8 sweep on a position-dependent mask
    for (int i = K - 1; i >= 0; i--) write_lim(6 + 3 * i, -6 - 2 * i);
    for (int n = 0; n < 800; n++) begin
      a = rnd(28, -14);
      b = rnd(28, -14);
      push("R8 sweep", a, a - rnd(4, 0), b, b - rnd(4, 0));
      if (n % 37 == 0) idle_garbage(2);
      if (n % 97 == 96) begin set_en(0); set_en(1); end
    end

    // R11 while disabled, data ignored by output
    set_en(0);
    ref_trig = 1; ref_lane = 1;
    push("R11 disabled pass", 0, 0, 0, 0);
    @(negedge clk);
    chk("R11 disabled lane", int'(trig_lane), 1);
    ref_trig = 0; ref_lane = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule